// File: doc/BRIEF.md
# Secure Configuration Load Gate

This block is the policy stage that sits in front of the bitstream datapath of a configurable device. Each time a configuration load is requested, it looks at the key currently provisioned (none, battery-backed volatile, or one-time programmed), a write-once tamper lock, the load path chosen (passive serial, fast parallel, active serial or the test port), and two flags carried by the stream header: encrypted and compressed. From these it decides whether the load may proceed. It also tells the downstream datapath which transforms to apply and in which order, and which data-clock to data-word ratio the host must supply.

The decision is taken from the inputs present in the request cycle. It is then held unchanged until the next request, so a key or header input that moves in the middle of a load cannot alter the policy that applies to that load. A refused load raises a sticky error flag, which only the next request can clear. The tamper lock can be set only while a one-time key is present, and after that nothing but power-on reset clears it.

Top module: `cfg_load_gate`

## Requirements
- R1: With no key present (key code 0, or the unused code 3), an encrypted stream is refused and an unencrypted one is accepted, with the board-test flag low.
- R2: With a volatile key (code 1) or a one-time key (code 2) and the tamper lock clear, unencrypted and encrypted streams are both accepted on the non-test paths; an accepted unencrypted load raises the board-test flag.
- R3: While the tamper lock is set, every unencrypted stream is refused, whatever the key code and the path, the test path (code 3) included.
- R4: An encrypted stream on the test path (path code 3) is always refused.
- R5: The tamper lock is set by a program pulse only in a cycle where the key code is 2. No input clears it once set; only the active-low reset does.
- R6: The transform order output reads 0 for pass-through, 1 for decrypt only, 2 for decompress only and 3 for decrypt followed by decompress. It reads 0 whenever the load is refused.
- R7: The clock ratio output is FAST_RATIO (default 4) for an accepted encrypted load on the fast parallel path (path code 1). In every other case it is 1.
- R8: While the tamper lock is set, encrypted streams on non-test paths are still accepted, on any number of later requests.
- R9: The error flag is set by a refused request and stays set until the next request, which replaces it with that request's own outcome.
- R10: Outputs change only in the cycle after a request. The inputs present in the request cycle are used, and a lock-program pulse in that same cycle already counts. Outputs then hold until the next request.
- R11: After reset, valid, accept, error, board-test and tamper-lock all read 0, the order reads 0 and the ratio reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| load_req | input | 1 | One-cycle pulse: a new configuration load begins |
| key_kind | input | 2 | 0 none, 1 volatile, 2 one-time, 3 treated as none |
| lock_prog | input | 1 | Request to set the tamper lock |
| load_path | input | 2 | 0 passive serial, 1 fast parallel, 2 active serial, 3 test port |
| stream_enc | input | 1 | Stream is encrypted |
| stream_cmp | input | 1 | Stream is compressed |
| decision_valid | output | 1 | A request has been evaluated since reset |
| load_ok | output | 1 | Current load is allowed |
| reject_err | output | 1 | Sticky refusal flag |
| board_test | output | 1 | Accepted load is a plaintext board-test load |
| xform_order | output | 2 | Datapath transform selection and order |
| clk_ratio | output | RATIO_W | Required data clock per data word |
| tamper_locked | output | 1 | Tamper lock state |

## Verification
A lock-program pulse and a load request can arrive in the same cycle. The request must then already see the lock as set, so the programming and the policy evaluation overlap in one cycle. The bench provokes this after a fresh reset: it pulses both together with a one-time key and a plaintext stream, and it expects a refusal with the error flag set in the very next cycle. The random phase sets the program pulse and the request independently, so the two also coincide under mixed key codes, including codes where the pulse must have no effect. A reference model judges each of these cases.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_VOL  = 2'd1,
        KEY_OTP  = 2'd2,
        KEY_RSVD = 2'd3
    } key_e;

    typedef enum logic [1:0] {
        LD_PS   = 2'd0,
        LD_FPP  = 2'd1,
        LD_AS   = 2'd2,
        LD_TEST = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_DEC      = 2'd1,
        XF_DCMP     = 2'd2,
        XF_DEC_DCMP = 2'd3
    } xform_e;

endpackage

// File: rtl/cfg_policy.sv
module cfg_policy
    import cfg_gate_pkg::*;
#(
    parameter int RATIO_W    = 3,
    parameter int FAST_RATIO = 4
) (
    input  key_e               key_i,
    input  logic               locked_i,
    input  path_e              path_i,
    input  logic               enc_i,
    input  logic               cmp_i,
    output logic               ok_o,
    output logic               bt_o,
    output xform_e             order_o,
    output logic [RATIO_W-1:0] ratio_o
);

    localparam logic [RATIO_W-1:0] RATIO_ONE  = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] RATIO_FAST = RATIO_W'(FAST_RATIO);

    logic has_key;
    logic bad_test_enc;
    logic bad_nokey_enc;
    logic bad_lock_plain;

    always_comb begin
        has_key        = (key_i == KEY_VOL) || (key_i == KEY_OTP);
        bad_test_enc   = (path_i == LD_TEST) && enc_i;
        bad_nokey_enc  = !has_key && enc_i;
        bad_lock_plain = locked_i && !enc_i;
        ok_o           = !(bad_test_enc || bad_nokey_enc || bad_lock_plain);
        bt_o           = ok_o && !enc_i && has_key;
        if (!ok_o) begin
            order_o = XF_NONE;
        end else begin
            unique case ({cmp_i, enc_i})
                2'b01:   order_o = XF_DEC;
                2'b10:   order_o = XF_DCMP;
                2'b11:   order_o = XF_DEC_DCMP;
                default: order_o = XF_NONE;
            endcase
        end
        ratio_o = (ok_o && enc_i && (path_i == LD_FPP)) ? RATIO_FAST : RATIO_ONE;
    end

endmodule

// File: rtl/tamper_lock.sv
module tamper_lock
    import cfg_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_i,
    input  key_e key_i,
    output logic lock_q_o,
    output logic lock_d_o
);

    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (prog_i && (key_i == KEY_OTP)) begin
            lock_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign lock_q_o = lock_q;
    assign lock_d_o = lock_d;

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_lock_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !(prog_i && key_i == KEY_OTP)) |=> !lock_q);

endmodule

// File: rtl/cfg_load_gate.sv
module cfg_load_gate
    import cfg_gate_pkg::*;
#(
    parameter int RATIO_W    = 3,
    parameter int FAST_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_req,
    input  logic [1:0]         key_kind,
    input  logic               lock_prog,
    input  logic [1:0]         load_path,
    input  logic               stream_enc,
    input  logic               stream_cmp,
    output logic               decision_valid,
    output logic               load_ok,
    output logic               reject_err,
    output logic               board_test,
    output logic [1:0]         xform_order,
    output logic [RATIO_W-1:0] clk_ratio,
    output logic               tamper_locked
);

    localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

    typedef struct packed {
        logic               valid;
        logic               ok;
        logic               err;
        logic               bt;
        xform_e             order;
        logic [RATIO_W-1:0] ratio;
        path_e              held_path;
        logic               held_enc;
    } gate_t;

    gate_t gate_d, gate_q;

    key_e               key_w;
    path_e              path_w;
    logic               lock_q, lock_d;
    logic               pol_ok, pol_bt;
    xform_e             pol_order;
    logic [RATIO_W-1:0] pol_ratio;

    assign key_w  = key_e'(key_kind);
    assign path_w = path_e'(load_path);

    tamper_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_i   (lock_prog),
        .key_i    (key_w),
        .lock_q_o (lock_q),
        .lock_d_o (lock_d)
    );

    cfg_policy #(
        .RATIO_W    (RATIO_W),
        .FAST_RATIO (FAST_RATIO)
    ) u_policy (
        .key_i    (key_w),
        .locked_i (lock_d),
        .path_i   (path_w),
        .enc_i    (stream_enc),
        .cmp_i    (stream_cmp),
        .ok_o     (pol_ok),
        .bt_o     (pol_bt),
        .order_o  (pol_order),
        .ratio_o  (pol_ratio)
    );

    always_comb begin
        gate_d = gate_q;
        if (load_req) begin
            gate_d.valid     = 1'b1;
            gate_d.ok        = pol_ok;
            gate_d.err       = !pol_ok;
            gate_d.bt        = pol_bt;
            gate_d.order     = pol_order;
            gate_d.ratio     = pol_ratio;
            gate_d.held_path = path_w;
            gate_d.held_enc  = stream_enc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '{valid: 1'b0, ok: 1'b0, err: 1'b0, bt: 1'b0,
                        order: XF_NONE, ratio: RATIO_ONE,
                        held_path: LD_PS, held_enc: 1'b0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign decision_valid = gate_q.valid;
    assign load_ok        = gate_q.ok;
    assign reject_err     = gate_q.err;
    assign board_test     = gate_q.bt;
    assign xform_order    = gate_q.order;
    assign clk_ratio      = gate_q.ratio;
    assign tamper_locked  = lock_q;

    assert_test_no_enc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.valid && gate_q.held_path == LD_TEST && gate_q.held_enc) |-> !gate_q.ok);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> $stable(gate_q));

    assert_err_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (gate_q.err != gate_q.ok));

    assert_fast_ratio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.ratio != RATIO_ONE) |-> (gate_q.ok && gate_q.held_enc && gate_q.held_path == LD_FPP));

    assert_order_when_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q.ok |-> (gate_q.order == XF_NONE));

endmodule

// File: tb/cfg_load_gate_tb.sv
module cfg_load_gate_tb_top;

    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_req = 1'b0;
    logic [1:0]    key_kind = 2'd0;
    logic          lock_prog = 1'b0;
    logic [1:0]    load_path = 2'd0;
    logic          stream_enc = 1'b0;
    logic          stream_cmp = 1'b0;
    logic          decision_valid, load_ok, reject_err, board_test, tamper_locked;
    logic [1:0]    xform_order;
    logic [RW-1:0] clk_ratio;

    int checks = 0;
    int failures = 0;

    logic          e_valid, e_ok, e_err, e_bt, e_lock;
    logic [1:0]    e_order;
    logic [RW-1:0] e_ratio;

    always #2 clk = ~clk;

    cfg_load_gate #(.RATIO_W(RW), .FAST_RATIO(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .key_kind(key_kind),
        .lock_prog(lock_prog), .load_path(load_path), .stream_enc(stream_enc),
        .stream_cmp(stream_cmp), .decision_valid(decision_valid), .load_ok(load_ok),
        .reject_err(reject_err), .board_test(board_test), .xform_order(xform_order),
        .clk_ratio(clk_ratio), .tamper_locked(tamper_locked)
    );

    function automatic logic f_ok(logic [1:0] k, logic lk, logic [1:0] p, logic e);
        logic hk = (k == 2'd1) || (k == 2'd2);
        if (p == 2'd3 && e) return 1'b0;
        if (!hk && e)       return 1'b0;
        if (lk && !e)       return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        e_valid = 0; e_ok = 0; e_err = 0; e_bt = 0; e_lock = 0;
        e_order = 2'd0; e_ratio = RW'(1);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "valid",  decision_valid, e_valid);
        chk(tag, "ok",     load_ok,        e_ok);
        chk(tag, "err",    reject_err,     e_err);
        chk(tag, "bt",     board_test,     e_bt);
        chk(tag, "order",  xform_order,    e_order);
        chk(tag, "ratio",  clk_ratio,      e_ratio);
        chk(tag, "lock",   tamper_locked,  e_lock);
    endtask

    // called at a negedge: drive, update model, check at next negedge
    task automatic step(logic [1:0] k, logic pg, logic [1:0] p, logic e, logic c,
                        logic rq, string tag);
        logic lk;
        key_kind = k; lock_prog = pg; load_path = p; stream_enc = e;
        stream_cmp = c; load_req = rq;
        lk = e_lock | (pg && k == 2'd2);
        if (rq) begin
            e_valid = 1'b1;
            e_ok    = f_ok(k, lk, p, e);
            e_err   = !e_ok;
            e_bt    = e_ok && !e && (k == 2'd1 || k == 2'd2);
            e_order = e_ok ? {c, e} : 2'd0;
            e_ratio = (e_ok && e && p == 2'd1) ? RW'(4) : RW'(1);
        end
        e_lock = lk;
        @(negedge clk);
        check_all(tag);
        load_req = 1'b0; lock_prog = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; load_req = 1'b0; lock_prog = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        check_all("R11");                    // reset state
        step(2'd0, 0, 2'd0, 1, 0, 1, "R1");  // no key, encrypted: refused
        step(2'd3, 0, 2'd2, 0, 0, 1, "R1");  // code 3 plain: accepted, no board-test
        step(2'd3, 0, 2'd2, 1, 0, 1, "R1");  // code 3 encrypted: refused
        step(2'd1, 0, 2'd0, 0, 1, 1, "R2");  // volatile plain compressed: board-test
        step(2'd1, 0, 2'd2, 1, 0, 1, "R2");  // volatile encrypted
        step(2'd2, 0, 2'd1, 1, 1, 1, "R6");  // decrypt then decompress, ratio 4 (R7)
        step(2'd2, 0, 2'd0, 1, 0, 1, "R7");  // serial encrypted: ratio 1
        step(2'd1, 0, 2'd3, 1, 0, 1, "R4");  // test path encrypted: refused
        step(2'd1, 1, 2'd2, 0, 0, 1, "R5");  // program with volatile key ignored
        step(2'd2, 1, 2'd3, 0, 0, 0, "R5");  // program with one-time key sets lock
        step(2'd1, 0, 2'd3, 0, 0, 1, "R3");  // locked, test path plain: refused
        step(2'd2, 0, 2'd0, 0, 1, 1, "R3");  // locked, serial plain: refused
        step(2'd1, 0, 2'd1, 0, 0, 0, "R9");  // no request: error stays set
        step(2'd1, 0, 2'd1, 1, 0, 1, "R8");  // locked encrypted: accepted, error cleared
        step(2'd0, 0, 2'd3, 1, 1, 0, "R10"); // inputs move without request: held
        step(2'd2, 0, 2'd2, 1, 1, 1, "R8");  // locked encrypted again
        do_reset();
        check_all("R5");                     // lock cleared only by reset
        step(2'd2, 1, 2'd2, 0, 0, 1, "R10"); // same-cycle program and plain request
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            logic [1:0] k = 2'($urandom);
            logic [1:0] p = 2'($urandom);
            logic       pg = ($urandom % 50) == 0;
            logic       rq = ($urandom % 3) != 0;
            step(k, pg, p, 1'($urandom), 1'($urandom), rq, "R10");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule